// File: doc/BRIEF.md
# Boundary-Scan Pin Register

This block is the chain of boundary-scan cells that wraps a set of bidirectional I/O pins. Every pin carries three cells: one for the pad input, one for the core's output value and one for the core's output enable. Each cell has a capture flop and an update flop. The capture flops, joined end to end, form a serial shift path from TDI to TDO. The update flops hold the values that are forced onto the pins during an external-connection test.

The test access port controller and the instruction register sit outside this block. They supply the capture, shift and update strobes and a two-bit mode code. Outside the external test mode, core data and enables pass straight to the pads, so loading or sampling the chain never disturbs normal operation. A global device output-enable input can hold every pin tri-stated. While it does, the enable cells still record what the core is requesting.

Top module: `bscan_register`

## Requirements
- R1: On a rising TCK edge with capture_dr high, each pin's input cell loads pad_in, its output cell loads core_out and its enable cell loads core_oe, in every mode. Capture takes priority over shift.
- R2: On a rising TCK edge with shift_dr high and capture_dr low, the chain moves by one position. Chain position 0 loads tdi. Pin p owns positions 3p (input), 3p+1 (output) and 3p+2 (enable), so pin 0's input cell is nearest TDI.
- R3: tdo is registered on the falling TCK edge from the last chain position (3N-1, the enable cell of the highest pin). After a capture, the first bit seen on tdo is that cell's captured value. A bit entered on tdi appears on tdo at the 3N-th falling edge after it enters.
- R4: Update flops load the capture flop values only on a falling TCK edge with update_dr high. They keep their values through capture and shift, so the forced pins stay steady between the rising edge and the next falling edge of an update cycle.
- R5: In mode 2'b00 (normal), 2'b01 (sample/preload) or 2'b11 (treated as normal), pad_out equals core_out combinationally.
- R6: Outside mode 2'b10, pad_oe equals core_oe when dev_oe is 1 and is all 0 when dev_oe is 0. The enable cells still capture core_oe while dev_oe is 0.
- R7: In mode 2'b10 (external test), pad_out[p] is the output-cell update flop and pad_oe[p] is the enable-cell update flop (1 drives the pin), independent of core_out, core_oe and dev_oe.
- R8: core_in equals pad_in in every mode, including external test.
- R9: trst_n low asynchronously clears all capture flops, all update flops and tdo to 0. In external test mode right after reset, pad_oe is therefore all 0 and pad_out is all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test-logic reset, active low |
| mode | input | 2 | 00 normal, 01 sample/preload, 10 external test, 11 normal |
| capture_dr | input | 1 | Capture strobe, sampled on rising TCK |
| shift_dr | input | 1 | Shift strobe, sampled on rising TCK |
| update_dr | input | 1 | Update strobe, sampled on falling TCK |
| tdi | input | 1 | Serial data into chain position 0 |
| dev_oe | input | 1 | Global device output enable; 0 tri-states pins outside external test |
| core_out | input | NUM_PINS | Core output data per pin |
| core_oe | input | NUM_PINS | Core output enable per pin, 1 drives |
| pad_in | input | NUM_PINS | Value seen at each pad |
| pad_out | output | NUM_PINS | Data toward each pad driver |
| pad_oe | output | NUM_PINS | Enable toward each pad driver, 1 drives |
| core_in | output | NUM_PINS | Pad value delivered to the core |
| tdo | output | 1 | Serial chain output, changes on falling TCK |

## Verification
The pass-through muxes are tried across all four mode codes, with dev_oe both high and low and with mixed data and enable patterns. This separates the normal and sample paths from the reserved code and shows the enable gating acting on its own. A sample capture made with dev_oe low and a high enable bit on the top pin is shifted out and then refilled from a non-repeating tdi pattern. The leading bits show that the enable cell recorded the core request rather than the tri-state. The trailing bits show the full chain latency and the cell order. Under external test, the bench confirms that a shift leaves the forced pins unchanged and that an update takes effect only at the falling edge. It also captures a pad pattern that differs from the driven values and checks that an asynchronous reset releases every pin at once.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

   typedef enum logic [1:0] {
      BS_MODE_NORMAL = 2'b00,
      BS_MODE_SAMPLE = 2'b01,
      BS_MODE_EXTEST = 2'b10,
      BS_MODE_RSVD   = 2'b11
   } bs_mode_e;

   localparam int unsigned BS_CELLS_PER_PIN = 3;
   localparam int unsigned BS_SLOT_IN       = 0;
   localparam int unsigned BS_SLOT_OUT      = 1;
   localparam int unsigned BS_SLOT_OE       = 2;

   // update-flop reset level of an enable cell: 0 = pin released
   localparam logic BS_OE_RELEASED = 1'b0;

endpackage

// File: rtl/bscan_cell.sv
module bscan_cell #(
   parameter logic UPD_RESET = 1'b0
) (
   input  logic tck,
   input  logic trst_n,
   input  logic capture_en,
   input  logic shift_en,
   input  logic update_en,
   input  logic par_in,
   input  logic ser_in,
   output logic cap_q,
   output logic upd_q
);

   // capture / shift stage, rising edge
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)         cap_q <= 1'b0;
      else if (capture_en) cap_q <= par_in;
      else if (shift_en)   cap_q <= ser_in;
   end

   // update stage, falling edge so pins settle away from shifting
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n)         upd_q <= UPD_RESET;
      else if (update_en)  upd_q <= cap_q;
   end

endmodule

// File: rtl/bscan_pin.sv
module bscan_pin
   import bscan_pkg::*;
#(
   parameter bit ENABLE_DEV_OE = 1'b1
) (
   input  logic       tck,
   input  logic       trst_n,
   input  logic       capture_en,
   input  logic       shift_en,
   input  logic       update_en,
   input  logic       extest,
   input  logic       dev_oe,
   input  logic       ser_in,
   input  logic       core_out,
   input  logic       core_oe,
   input  logic       pad_in,
   output logic       ser_out,
   output logic [BS_CELLS_PER_PIN-1:0] cap_vec,
   output logic       pad_out,
   output logic       pad_oe,
   output logic       core_in
);

   localparam int unsigned NC = BS_CELLS_PER_PIN;

   logic [NC-1:0] par;
   logic [NC-1:0] upd;
   logic [NC:0]   link;
   logic          oe_func;

   always_comb begin
      par             = '0;
      par[BS_SLOT_IN]  = pad_in;
      par[BS_SLOT_OUT] = core_out;
      par[BS_SLOT_OE]  = core_oe;
   end

   assign link[0] = ser_in;

   for (genvar s = 0; s < NC; s++) begin : g_cell
      localparam logic RV = (s == BS_SLOT_OE) ? BS_OE_RELEASED : 1'b0;
      bscan_cell #(.UPD_RESET(RV)) i_cell (
         .tck        (tck),
         .trst_n     (trst_n),
         .capture_en (capture_en),
         .shift_en   (shift_en),
         .update_en  (update_en),
         .par_in     (par[s]),
         .ser_in     (link[s]),
         .cap_q      (link[s+1]),
         .upd_q      (upd[s])
      );
   end

   assign cap_vec = link[NC:1];
   assign ser_out = link[NC];

   if (ENABLE_DEV_OE) begin : g_devoe
      assign oe_func = core_oe & dev_oe;
   end else begin : g_no_devoe
      assign oe_func = core_oe;
   end

   assign pad_out = extest ? upd[BS_SLOT_OUT] : core_out;
   assign pad_oe  = extest ? upd[BS_SLOT_OE]  : oe_func;
   assign core_in = pad_in;

   // the input-cell update flop is loaded but never drives anything
   logic unused_in_upd;
   assign unused_in_upd = upd[BS_SLOT_IN];

endmodule

// File: rtl/bscan_tdo_stage.sv
module bscan_tdo_stage (
   input  logic tck,
   input  logic trst_n,
   input  logic chain_last,
   output logic tdo
);

   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) tdo <= 1'b0;
      else         tdo <= chain_last;
   end

endmodule

// File: rtl/bscan_register.sv
module bscan_register
   import bscan_pkg::*;
#(
   parameter int unsigned NUM_PINS      = 8,
   parameter bit          ENABLE_DEV_OE = 1'b1
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic [1:0]          mode,
   input  logic                capture_dr,
   input  logic                shift_dr,
   input  logic                update_dr,
   input  logic                tdi,
   input  logic                dev_oe,
   input  logic [NUM_PINS-1:0] core_out,
   input  logic [NUM_PINS-1:0] core_oe,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] core_in,
   output logic                tdo
);

   localparam int unsigned NC        = BS_CELLS_PER_PIN;
   localparam int unsigned CHAIN_LEN = NUM_PINS * NC;

   if (NUM_PINS < 1 || NUM_PINS > 1024) begin : g_bad_pins
      $error("bscan_register: NUM_PINS must be in 1..1024");
   end

   logic                 extest;
   logic [NUM_PINS:0]    link;
   logic [CHAIN_LEN-1:0] cap_chain;

   assign extest  = (mode == BS_MODE_EXTEST);
   assign link[0] = tdi;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      bscan_pin #(.ENABLE_DEV_OE(ENABLE_DEV_OE)) i_pin (
         .tck        (tck),
         .trst_n     (trst_n),
         .capture_en (capture_dr),
         .shift_en   (shift_dr),
         .update_en  (update_dr),
         .extest     (extest),
         .dev_oe     (dev_oe),
         .ser_in     (link[p]),
         .core_out   (core_out[p]),
         .core_oe    (core_oe[p]),
         .pad_in     (pad_in[p]),
         .ser_out    (link[p+1]),
         .cap_vec    (cap_chain[p*NC +: NC]),
         .pad_out    (pad_out[p]),
         .pad_oe     (pad_oe[p]),
         .core_in    (core_in[p])
      );
   end

   bscan_tdo_stage i_tdo (
      .tck        (tck),
      .trst_n     (trst_n),
      .chain_last (link[NUM_PINS]),
      .tdo        (tdo)
   );

endmodule

// File: rtl/bscan_register_chk.sv
module bscan_register_chk
   import bscan_pkg::*;
#(
   parameter int unsigned NUM_PINS      = 8,
   parameter bit          ENABLE_DEV_OE = 1'b1
) (
   input logic                          tck,
   input logic                          trst_n,
   input logic [1:0]                    mode,
   input logic                          capture_dr,
   input logic                          shift_dr,
   input logic                          update_dr,
   input logic                          tdi,
   input logic                          dev_oe,
   input logic [NUM_PINS-1:0]           core_out,
   input logic                          core_oe0,
   input logic                          pad_in0,
   input logic [NUM_PINS-1:0]           pad_out,
   input logic [NUM_PINS-1:0]           pad_oe,
   input logic                          tdo,
   input logic [NUM_PINS*3-1:0]         cap_chain
);

   localparam int unsigned L = NUM_PINS * 3;

   logic armed;
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) armed <= 1'b0;
      else         armed <= 1'b1;
   end

   p_capture_pin0_r1: assert property (@(posedge tck) disable iff (!trst_n)
      capture_dr |=> (cap_chain[0] == $past(pad_in0)) &&
                     (cap_chain[1] == $past(core_out[0])) &&
                     (cap_chain[2] == $past(core_oe0)));

   if (L > 1) begin : g_shift_chk
      p_shift_move_r2: assert property (@(posedge tck) disable iff (!trst_n)
         (shift_dr && !capture_dr) |=>
            (cap_chain[0] == $past(tdi)) &&
            (cap_chain[L-1:1] == $past(cap_chain[L-2:0])));
   end

   p_tdo_tracks_r3: assert property (@(posedge tck) disable iff (!trst_n)
      tdo == cap_chain[L-1]);

   p_forced_hold_r4: assert property (@(negedge tck) disable iff (!trst_n)
      (armed && mode == BS_MODE_EXTEST && $past(mode) == BS_MODE_EXTEST &&
       !$past(update_dr)) |-> ($stable(pad_out) && $stable(pad_oe)));

   p_core_pass_r5: assert property (@(posedge tck) disable iff (!trst_n)
      (mode != BS_MODE_EXTEST) |-> (pad_out == core_out));

   if (ENABLE_DEV_OE) begin : g_devoe_chk
      p_global_tristate_r6: assert property (@(posedge tck) disable iff (!trst_n)
         (mode != BS_MODE_EXTEST && !dev_oe) |-> (pad_oe == '0));
   end

endmodule

bind bscan_register bscan_register_chk #(
   .NUM_PINS      (NUM_PINS),
   .ENABLE_DEV_OE (ENABLE_DEV_OE)
) i_chk (
   .tck        (tck),
   .trst_n     (trst_n),
   .mode       (mode),
   .capture_dr (capture_dr),
   .shift_dr   (shift_dr),
   .update_dr  (update_dr),
   .tdi        (tdi),
   .dev_oe     (dev_oe),
   .core_out   (core_out),
   .core_oe0   (core_oe[0]),
   .pad_in0    (pad_in[0]),
   .pad_out    (pad_out),
   .pad_oe     (pad_oe),
   .tdo        (tdo),
   .cap_chain  (cap_chain)
);

// File: tb/test_bscan_register.sv
`timescale 1ns/1ps
module test_bscan_register;
   import bscan_pkg::*;

   localparam int NP     = 4;
   localparam int L      = NP * 3;
   localparam int TCK_NS = 8;

   logic          tck = 1'b0;
   logic          trst_n, capture_dr, shift_dr, update_dr, tdi, dev_oe;
   logic [1:0]    mode;
   logic [NP-1:0] core_out, core_oe, pad_in, pad_out, pad_oe, core_in;
   logic          tdo;

   always #(TCK_NS/2) tck = ~tck;

   bscan_register #(.NUM_PINS(NP), .ENABLE_DEV_OE(1'b1)) i_bscan_register (
      .tck(tck), .trst_n(trst_n), .mode(mode), .capture_dr(capture_dr),
      .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .dev_oe(dev_oe),
      .core_out(core_out), .core_oe(core_oe), .pad_in(pad_in),
      .pad_out(pad_out), .pad_oe(pad_oe), .core_in(core_in), .tdo(tdo));

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   logic [L-1:0] m_chain = '0;
   logic [L-1:0] m_upd   = '0;

   typedef struct packed {
      logic [1:0] md;
      logic       dv;
      logic [3:0] co;
      logic [3:0] coe;
      logic [3:0] pin;
      logic [3:0] eo;
      logic [3:0] eoe;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'b00, 1'b1, 4'hA, 4'hF, 4'h3, 4'hA, 4'hF},
      '{2'b01, 1'b1, 4'h5, 4'h6, 4'hC, 4'h5, 4'h6},
      '{2'b00, 1'b0, 4'hF, 4'hF, 4'h0, 4'hF, 4'h0},
      '{2'b01, 1'b0, 4'h3, 4'h9, 4'h7, 4'h3, 4'h0},
      '{2'b11, 1'b1, 4'hC, 4'h3, 4'h5, 4'hC, 4'h3},
      '{2'b11, 1'b0, 4'h6, 4'hE, 4'h9, 4'h6, 4'h0}
   };

   localparam logic [2*L-1:0] PAT_A = 24'hB4E1D2;
   localparam logic [L-1:0]   PAT_B = 12'h9C6;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [NP-1:0] upd_slot(input logic [L-1:0] u, input int slot);
      logic [NP-1:0] r;
      for (int p = 0; p < NP; p++) r[p] = u[3*p + slot];
      return r;
   endfunction

   // one TCK period: rising edge, falling edge, then the bench model follows
   task automatic step();
      @(posedge tck);
      @(negedge tck);
      #1;
      if (capture_dr) begin
         for (int p = 0; p < NP; p++) begin
            m_chain[3*p]   = pad_in[p];
            m_chain[3*p+1] = core_out[p];
            m_chain[3*p+2] = core_oe[p];
         end
      end else if (shift_dr) begin
         m_chain = {m_chain[L-2:0], tdi};
      end
      if (update_dr) m_upd = m_chain;
   endtask

   initial begin
      #(200000 * TCK_NS);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      trst_n = 1'b0; mode = BS_MODE_EXTEST; capture_dr = 0; shift_dr = 0;
      update_dr = 0; tdi = 0; dev_oe = 1; core_out = '1; core_oe = '1; pad_in = '0;
      repeat (2) @(negedge tck);
      #1;
      // R9: reset state in external test mode
      check("R9 reset pad_oe", pad_oe, 0);
      check("R9 reset pad_out", pad_out, 0);
      check("R9 reset tdo", tdo, 0);
      trst_n = 1'b1;

      // R5 R6 R8: pass-through table
      for (int i = 0; i < 6; i++) begin
         mode = VECS[i].md; dev_oe = VECS[i].dv; core_out = VECS[i].co;
         core_oe = VECS[i].coe; pad_in = VECS[i].pin;
         #1;
         check("R5 pass pad_out", pad_out, VECS[i].eo);
         check("R6 pass pad_oe", pad_oe, VECS[i].eoe);
         check("R8 pass core_in", core_in, VECS[i].pin);
      end
      @(negedge tck); #1;

      // R1 R3 R6: sample capture while pins held tri-state
      mode = BS_MODE_SAMPLE; dev_oe = 0;
      core_out = 4'b1011; core_oe = 4'b1010; pad_in = 4'b1100;
      capture_dr = 1; step(); capture_dr = 0;
      check("R6 enable cell captured core request on tdo", tdo, 1);
      check("R3 first bit after capture", tdo, m_chain[L-1]);
      check("R6 pins tri-stated during sample", pad_oe, 0);
      check("R5 core data undisturbed during sample", pad_out, 4'b1011);

      // R2 R3: shift captured bits out, then the tdi pattern through
      shift_dr = 1;
      for (int j = 0; j < 2*L; j++) begin
         tdi = PAT_A[j];
         step();
         check("R2 R3 shift tdo", tdo, m_chain[L-1]);
         if (j >= L - 1) check("R3 tdi latency", tdo, PAT_A[j-L+1]);
      end
      shift_dr = 0;

      // R4: update under sample leaves pins on core data
      update_dr = 1; step(); update_dr = 0;
      check("R5 pins still core after update", pad_out, 4'b1011);

      // R7: external test drives update values regardless of core
      mode = BS_MODE_EXTEST; core_out = 4'b0000; core_oe = 4'b0000; dev_oe = 0;
      #1;
      check("R7 forced pad_out", pad_out, upd_slot(m_upd, BS_SLOT_OUT));
      check("R7 forced pad_oe", pad_oe, upd_slot(m_upd, BS_SLOT_OE));

      // R4: shifting under external test does not move the pins
      shift_dr = 1;
      for (int j = 0; j < L; j++) begin
         tdi = PAT_B[j];
         step();
         check("R4 pins hold while shifting", {pad_oe, pad_out},
               {upd_slot(m_upd, BS_SLOT_OE), upd_slot(m_upd, BS_SLOT_OUT)});
      end
      shift_dr = 0;

      // R4: update lands on the falling edge only
      update_dr = 1;
      @(posedge tck); #1;
      check("R4 no change at rising edge", {pad_oe, pad_out},
            {upd_slot(m_upd, BS_SLOT_OE), upd_slot(m_upd, BS_SLOT_OUT)});
      @(negedge tck); #1;
      m_upd = m_chain;
      update_dr = 0;
      check("R4 R7 new pad_out after falling edge", pad_out, upd_slot(m_upd, BS_SLOT_OUT));
      check("R4 R7 new pad_oe after falling edge", pad_oe, upd_slot(m_upd, BS_SLOT_OE));

      // R1 R8: capture of pad values under external test
      pad_in = 4'b0101; core_out = 4'b1111; core_oe = 4'b0011;
      #1;
      check("R8 core_in follows pad in external test", core_in, 4'b0101);
      capture_dr = 1; shift_dr = 1; step(); capture_dr = 0;
      check("R1 capture wins over shift", tdo, m_chain[L-1]);
      for (int j = 0; j < L; j++) begin
         tdi = 1'b0;
         step();
         check("R1 readback shift", tdo, m_chain[L-1]);
      end
      shift_dr = 0;

      // R9: asynchronous reset releases the pins
      check("R9 pins driven before reset", (pad_oe != 0), 1);
      trst_n = 1'b0;
      #1;
      check("R9 async reset pad_oe", pad_oe, 0);
      check("R9 async reset pad_out", pad_out, 0);
      check("R9 async reset tdo", tdo, 0);

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule